// File: doc/BRIEF.md
# Precision Time-of-Day Clock

This block is a free-running hardware time-of-day counter. It holds two views of the same time at once. The first is a 96-bit value with a whole-seconds field over a nanosecond field that wraps at one second. The second is a 64-bit nanosecond count that never wraps. Both views carry 16 bits of fractional nanoseconds. On every clock cycle both views advance by a programmable period that has integer and fractional nanosecond parts.

A controlling agent, such as a servo running elsewhere, has three ways to steer the clock:
- It can overwrite either view directly.
- It can request an offset slew. The slew adds a small extra amount on top of the period for a set number of cycles, so the time moves by a known total with no jump.
- It can program a drift term. The drift is added once every N cycles, which gives a sub-fraction correction to the average rate.

The block raises a one-cycle strobe each time the seconds field increments. It raises a second one-cycle strobe whenever a direct load makes the time jump.

Top module: `tod_clock`

## Requirements
- R1: While reset is high and on the cycle after it, both timestamps read zero, and the seconds strobe, the step strobe and the slew-active flag are all low. Reset also restores the default period (6 ns + 0x6666/65536) and the default drift (0 ns + 2 fractional units every 5 cycles).
- R2: The 96-bit output carries whole seconds in bits 95:48. Bits 47:0 carry nanoseconds multiplied by 65536.
- R3: The 64-bit output is nanoseconds multiplied by 65536. On each clock edge without a load, both views advance by the same increment. That increment is the period, plus the slew amount while a slew runs, plus the drift amount on drift cycles.
- R4: When adding the increment brings the nanosecond field to 10^9·65536 or above, 10^9·65536 is subtracted from it and the seconds field increments. The seconds strobe is high for exactly that one cycle.
- R5: A load strobe on either view makes the supplied value appear on that view one cycle later, in place of the advance. The other view keeps advancing normally.
- R6: A new period accepted on its strobe is used for every advance from the following edge onward.
- R7: An offset request with count C adds its amount to the increment on the C edges that follow the request. The slew-active flag is high from the cycle after the request until the last of those edges. A count of zero has no effect.
- R8: The drift amount is added on every rate-th edge after the drift setting is written or after reset. A rate of zero disables drift.
- R9: The step strobe is high for exactly one cycle after any edge on which either load strobe was high, and is low otherwise.
- R10: An offset request that arrives while a slew is active replaces the remainder of that slew. The old amount still applies on the edge that accepts the new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld96_val | input | 96 | Value for the seconds/nanoseconds view |
| ld96_vld | input | 1 | Load strobe for the 96-bit view |
| ld64_val | input | 64 | Value for the nanosecond-count view |
| ld64_vld | input | 1 | Load strobe for the 64-bit view |
| per_ns | input | 4 | New period, integer nanoseconds |
| per_fns | input | 16 | New period, fractional nanoseconds |
| per_vld | input | 1 | Period update strobe |
| ofs_ns | input | 4 | Slew amount per cycle, integer nanoseconds |
| ofs_fns | input | 16 | Slew amount per cycle, fractional nanoseconds |
| ofs_cnt | input | 16 | Number of cycles the slew lasts |
| ofs_vld | input | 1 | Slew request strobe |
| ofs_active | output | 1 | A slew is in progress |
| drf_ns | input | 4 | Drift amount, integer nanoseconds |
| drf_fns | input | 16 | Drift amount, fractional nanoseconds |
| drf_rate | input | 16 | Edges between drift additions (0 disables) |
| drf_vld | input | 1 | Drift setting strobe |
| ts96 | output | 96 | Seconds plus wrapping nanoseconds view |
| ts64 | output | 64 | Non-wrapping nanosecond view |
| ts_step | output | 1 | One-cycle strobe after a direct load |
| pps | output | 1 | One-cycle strobe on each seconds increment |

## Verification
The rollover assertions assume two things about the inputs. Any value loaded into the 96-bit view must have a nanosecond field below 10^9·65536. The total increment must be far below one second, so that at most one wrap can happen per edge. The directed scenarios keep every loaded nanosecond field a few periods short of the wrap limit and keep all increments in the single-digit nanosecond range. The step and load checks rely on the load strobes being low during reset, and the bench holds them low there.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam longint unsigned NS_PER_SEC = 64'd1_000_000_000;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/tod_slew.sv
module tod_slew #(
  parameter int NS_W  = 4,
  parameter int FNS_W = 16,
  parameter int CNT_W = 16,
  parameter int INC_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_vld,
  input  logic [NS_W-1:0]  req_ns,
  input  logic [FNS_W-1:0] req_fns,
  input  logic [CNT_W-1:0] req_cnt,
  output logic             active,
  output logic [INC_W-1:0] add
);
  localparam int AMT_W = NS_W + FNS_W;

  logic [CNT_W-1:0] remain;
  logic [AMT_W-1:0] amt;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      amt    <= '0;
    end else if (req_vld) begin
      remain <= req_cnt;
      amt    <= {req_ns, req_fns};
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign active = (remain != '0);
  assign add    = active ? INC_W'(amt) : '0;

  assert_slew_countdown_R7: assert property (@(posedge clk) disable iff (rst)
    (remain != '0 && !req_vld) |=> (remain == $past(remain) - 1'b1));
  assert_slew_restart_R10: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> (remain == $past(req_cnt)));
endmodule

// File: rtl/tod_drift.sv
module tod_drift #(
  parameter int          NS_W     = 4,
  parameter int          FNS_W    = 16,
  parameter int          RATE_W   = 16,
  parameter int          INC_W    = 22,
  parameter bit          ENABLE   = 1'b1,
  parameter int unsigned DEF_NS   = 0,
  parameter int unsigned DEF_FNS  = 2,
  parameter int unsigned DEF_RATE = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_vld,
  input  logic [NS_W-1:0]   set_ns,
  input  logic [FNS_W-1:0]  set_fns,
  input  logic [RATE_W-1:0] set_rate,
  output logic [INC_W-1:0]  add
);
  localparam int AMT_W = NS_W + FNS_W;

  generate
    if (ENABLE) begin : g_on
      logic [AMT_W-1:0]  amt;
      logic [RATE_W-1:0] rate;
      logic [RATE_W-1:0] phase;
      logic              fire;

      assign fire = (rate != '0) && (phase == rate - 1'b1);

      always_ff @(posedge clk) begin
        if (rst) begin
          amt   <= {NS_W'(DEF_NS), FNS_W'(DEF_FNS)};
          rate  <= RATE_W'(DEF_RATE);
          phase <= '0;
        end else if (set_vld) begin
          amt   <= {set_ns, set_fns};
          rate  <= set_rate;
          phase <= '0;
        end else if (rate != '0) begin
          phase <= fire ? '0 : phase + 1'b1;
        end
      end

      assign add = fire ? INC_W'(amt) : '0;

      assert_drift_phase_R8: assert property (@(posedge clk) disable iff (rst)
        (rate != '0) |-> (phase < rate));
    end else begin : g_off
      assign add = '0;
    end
  endgenerate
endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
  parameter int SEC_W = 48,
  parameter int NSF_W = 48,
  parameter int T64_W = 64,
  parameter int FNS_W = 16,
  parameter int INC_W = 22
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [INC_W-1:0]       inc,
  input  logic [SEC_W+NSF_W-1:0] ld96_val,
  input  logic                   ld96_vld,
  input  logic [T64_W-1:0]       ld64_val,
  input  logic                   ld64_vld,
  output logic [SEC_W+NSF_W-1:0] ts96,
  output logic [T64_W-1:0]       ts64,
  output logic                   pps,
  output logic                   step
);
  localparam logic [NSF_W:0] LIM = (NSF_W+1)'(tod_pkg::NS_PER_SEC << FNS_W);

  logic [SEC_W-1:0] sec;
  logic [NSF_W-1:0] nsf;
  logic [NSF_W:0]   sum_ns;
  logic [NSF_W:0]   nxt_ns;
  logic             wrap;

  always_comb begin
    sum_ns = {1'b0, nsf} + (NSF_W+1)'(inc);
    wrap   = (sum_ns >= LIM);
    nxt_ns = wrap ? (sum_ns - LIM) : sum_ns;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec  <= '0;
      nsf  <= '0;
      ts64 <= '0;
      pps  <= 1'b0;
      step <= 1'b0;
    end else begin
      if (ld96_vld) begin
        sec <= ld96_val[SEC_W+NSF_W-1:NSF_W];
        nsf <= ld96_val[NSF_W-1:0];
        pps <= 1'b0;
      end else begin
        sec <= sec + SEC_W'(wrap);
        nsf <= nxt_ns[NSF_W-1:0];
        pps <= wrap;
      end
      ts64 <= ld64_vld ? ld64_val : ts64 + T64_W'(inc);
      step <= ld96_vld | ld64_vld;
    end
  end

  assign ts96 = {sec, nsf};

  assert_ns_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, nsf} < LIM));
  assert_pps_sec_inc_R4: assert property (@(posedge clk) disable iff (rst)
    pps |-> (sec == $past(sec) + 1'b1));
  assert_load96_seen_R5: assert property (@(posedge clk) disable iff (rst)
    ld96_vld |=> (ts96 == $past(ld96_val)));
  assert_load64_seen_R5: assert property (@(posedge clk) disable iff (rst)
    ld64_vld |=> (ts64 == $past(ld64_val)));
  assert_step_on_load_R9: assert property (@(posedge clk) disable iff (rst)
    (ld96_vld || ld64_vld) |=> step);
  assert_step_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !(ld96_vld || ld64_vld) |=> !step);
endmodule

// File: rtl/tod_clock.sv
module tod_clock #(
  parameter int          PER_NS_W    = 4,
  parameter int          OFS_NS_W    = 4,
  parameter int          DRF_NS_W    = 4,
  parameter int          FNS_W       = 16,
  parameter int          CNT_W       = 16,
  parameter int          SEC_W       = 48,
  parameter int          NSF_W       = 48,
  parameter int          T64_W       = 64,
  parameter int unsigned DEF_PER_NS  = 6,
  parameter int unsigned DEF_PER_FNS = 16'h6666,
  parameter bit          DRF_EN      = 1'b1,
  parameter int unsigned DEF_DRF_NS  = 0,
  parameter int unsigned DEF_DRF_FNS = 2,
  parameter int unsigned DEF_DRF_RT  = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [SEC_W+NSF_W-1:0] ld96_val,
  input  logic                   ld96_vld,
  input  logic [T64_W-1:0]       ld64_val,
  input  logic                   ld64_vld,
  input  logic [PER_NS_W-1:0]    per_ns,
  input  logic [FNS_W-1:0]       per_fns,
  input  logic                   per_vld,
  input  logic [OFS_NS_W-1:0]    ofs_ns,
  input  logic [FNS_W-1:0]       ofs_fns,
  input  logic [CNT_W-1:0]       ofs_cnt,
  input  logic                   ofs_vld,
  output logic                   ofs_active,
  input  logic [DRF_NS_W-1:0]    drf_ns,
  input  logic [FNS_W-1:0]       drf_fns,
  input  logic [CNT_W-1:0]       drf_rate,
  input  logic                   drf_vld,
  output logic [SEC_W+NSF_W-1:0] ts96,
  output logic [T64_W-1:0]       ts64,
  output logic                   ts_step,
  output logic                   pps
);
  localparam int NS_MAX = tod_pkg::max3(PER_NS_W, OFS_NS_W, DRF_NS_W);
  localparam int INC_W  = NS_MAX + FNS_W + 2;

  logic [PER_NS_W+FNS_W-1:0] period;
  logic [INC_W-1:0]          slew_add;
  logic [INC_W-1:0]          drift_add;
  logic [INC_W-1:0]          inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      period <= {PER_NS_W'(DEF_PER_NS), FNS_W'(DEF_PER_FNS)};
    end else if (per_vld) begin
      period <= {per_ns, per_fns};
    end
  end

  assert_period_take_R6: assert property (@(posedge clk) disable iff (rst)
    per_vld |=> (period == {$past(per_ns), $past(per_fns)}));

  tod_slew #(
    .NS_W(OFS_NS_W), .FNS_W(FNS_W), .CNT_W(CNT_W), .INC_W(INC_W)
  ) u_slew (
    .clk(clk), .rst(rst), .req_vld(ofs_vld), .req_ns(ofs_ns),
    .req_fns(ofs_fns), .req_cnt(ofs_cnt), .active(ofs_active), .add(slew_add)
  );

  tod_drift #(
    .NS_W(DRF_NS_W), .FNS_W(FNS_W), .RATE_W(CNT_W), .INC_W(INC_W),
    .ENABLE(DRF_EN), .DEF_NS(DEF_DRF_NS), .DEF_FNS(DEF_DRF_FNS),
    .DEF_RATE(DEF_DRF_RT)
  ) u_drift (
    .clk(clk), .rst(rst), .set_vld(drf_vld), .set_ns(drf_ns),
    .set_fns(drf_fns), .set_rate(drf_rate), .add(drift_add)
  );

  assign inc = INC_W'(period) + slew_add + drift_add;

  tod_accum #(
    .SEC_W(SEC_W), .NSF_W(NSF_W), .T64_W(T64_W), .FNS_W(FNS_W), .INC_W(INC_W)
  ) u_accum (
    .clk(clk), .rst(rst), .inc(inc),
    .ld96_val(ld96_val), .ld96_vld(ld96_vld),
    .ld64_val(ld64_val), .ld64_vld(ld64_vld),
    .ts96(ts96), .ts64(ts64), .pps(pps), .step(ts_step)
  );
endmodule

// File: tb/tb_tod_clock.sv
module tb_tod_clock;
  localparam longint unsigned P   = 64'd419430;
  localparam longint unsigned LIM = 64'd65536000000000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [95:0] ld96_val = '0;
  logic        ld96_vld = 1'b0;
  logic [63:0] ld64_val = '0;
  logic        ld64_vld = 1'b0;
  logic [3:0]  per_ns = '0;
  logic [15:0] per_fns = '0;
  logic        per_vld = 1'b0;
  logic [3:0]  ofs_ns = '0;
  logic [15:0] ofs_fns = '0;
  logic [15:0] ofs_cnt = '0;
  logic        ofs_vld = 1'b0;
  logic        ofs_active;
  logic [3:0]  drf_ns = '0;
  logic [15:0] drf_fns = '0;
  logic [15:0] drf_rate = '0;
  logic        drf_vld = 1'b0;
  logic [95:0] ts96;
  logic [63:0] ts64;
  logic        ts_step;
  logic        pps;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  tod_clock dut (
    .clk(clk), .rst(rst),
    .ld96_val(ld96_val), .ld96_vld(ld96_vld),
    .ld64_val(ld64_val), .ld64_vld(ld64_vld),
    .per_ns(per_ns), .per_fns(per_fns), .per_vld(per_vld),
    .ofs_ns(ofs_ns), .ofs_fns(ofs_fns), .ofs_cnt(ofs_cnt), .ofs_vld(ofs_vld),
    .ofs_active(ofs_active),
    .drf_ns(drf_ns), .drf_fns(drf_fns), .drf_rate(drf_rate), .drf_vld(drf_vld),
    .ts96(ts96), .ts64(ts64), .ts_step(ts_step), .pps(pps)
  );

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_drift(input logic [3:0] ns, input logic [15:0] fns, input logic [15:0] rt);
    drf_ns = ns; drf_fns = fns; drf_rate = rt; drf_vld = 1'b1;
    tick();
    drf_vld = 1'b0;
  endtask

  task automatic zero64_with_slew(input logic [3:0] ns, input logic [15:0] fns, input logic [15:0] c);
    ld64_val = '0; ld64_vld = 1'b1;
    ofs_ns = ns; ofs_fns = fns; ofs_cnt = c; ofs_vld = 1'b1;
    tick();
    ld64_vld = 1'b0; ofs_vld = 1'b0;
  endtask

  task automatic t_reset_defaults();
    repeat (3) tick();
    chk("R1 ts96 in reset", ts96, '0);
    chk("R1 ts64 in reset", {32'd0, ts64}, '0);
    chk("R1 strobes in reset", {93'd0, pps, ts_step, ofs_active}, '0);
    rst = 1'b0;
    tick();
    chk("R1 ts64 one cycle after reset", {32'd0, ts64}, 96'(P));
    chk("R1 strobes after reset", {93'd0, pps, ts_step, ofs_active}, '0);
    repeat (9) tick();
    // 10 edges of default period plus two default drift additions (R8)
    chk("R8 default drift on ts64", {32'd0, ts64}, 96'(10 * P + 4));
    chk("R2 default drift on ts96", ts96, 96'(10 * P + 4));
  endtask

  task automatic t_loads();
    set_drift(0, 0, 0);
    ld96_val = {48'd3, 48'd12345}; ld96_vld = 1'b1;
    ld64_val = 64'd777;            ld64_vld = 1'b1;
    tick();
    ld96_vld = 1'b0; ld64_vld = 1'b0;
    chk("R5 ts96 load", ts96, {48'd3, 48'd12345});
    chk("R5 ts64 load", {32'd0, ts64}, 96'd777);
    chk("R9 step after load", {95'd0, ts_step}, 96'd1);
    tick();
    chk("R9 step one cycle only", {95'd0, ts_step}, '0);
    chk("R3 ts64 advance", {32'd0, ts64}, 96'(777 + P));
    ld64_val = '0; ld64_vld = 1'b1;
    tick();
    ld64_vld = 1'b0;
    chk("R5 ts96 keeps running during ts64 load", ts96, {48'd3, 48'(12345 + 2 * P)});
    chk("R9 step after ts64-only load", {95'd0, ts_step}, 96'd1);
    repeat (7) tick();
    chk("R3 ts64 after 7 edges", {32'd0, ts64}, 96'(7 * P));
  endtask

  task automatic t_period();
    per_ns = 4'd5; per_fns = 16'h8000; per_vld = 1'b1;
    ld64_val = '0; ld64_vld = 1'b1;
    tick();
    per_vld = 1'b0; ld64_vld = 1'b0;
    repeat (8) tick();
    chk("R6 new period", {32'd0, ts64}, 96'(8 * 360448));
    per_ns = 4'd6; per_fns = 16'h6666; per_vld = 1'b1;
    tick();
    per_vld = 1'b0;
  endtask

  task automatic t_rollover();
    ld96_val = {48'd3, 48'(LIM - 2 * P - 5)}; ld96_vld = 1'b1;
    tick();
    ld96_vld = 1'b0;
    tick();
    chk("R4 no pps before wrap", {95'd0, pps}, '0);
    tick();
    chk("R4 no pps at limit-5", {95'd0, pps}, '0);
    chk("R2 ns field just below limit", ts96, {48'd3, 48'(LIM - 5)});
    tick();
    chk("R4 pps on wrap", {95'd0, pps}, 96'd1);
    chk("R4 wrapped time", ts96, {48'd4, 48'(P - 5)});
    tick();
    chk("R4 pps one cycle", {95'd0, pps}, '0);
    chk("R4 after wrap", ts96, {48'd4, 48'(2 * P - 5)});
  endtask

  task automatic t_slew();
    zero64_with_slew(0, 16'd64, 16'd1024);
    chk("R7 active after request", {95'd0, ofs_active}, 96'd1);
    repeat (1023) tick();
    chk("R7 active on last slew cycle", {95'd0, ofs_active}, 96'd1);
    chk("R7 partial slew", {32'd0, ts64}, 96'(1023 * P + 1023 * 64));
    tick();
    chk("R7 inactive after count", {95'd0, ofs_active}, '0);
    chk("R7 total 1 ns offset", {32'd0, ts64}, 96'(1024 * P + 65536));
    tick();
    chk("R7 no slew after end", {32'd0, ts64}, 96'(1025 * P + 65536));
  endtask

  task automatic t_slew_replace();
    zero64_with_slew(0, 16'd10, 16'd100);
    repeat (40) tick();
    ofs_ns = 0; ofs_fns = 16'd3; ofs_cnt = 16'd20; ofs_vld = 1'b1;
    tick();
    ofs_vld = 1'b0;
    repeat (19) tick();
    chk("R10 replaced slew still active", {95'd0, ofs_active}, 96'd1);
    tick();
    chk("R10 replaced slew ends", {95'd0, ofs_active}, '0);
    chk("R10 replaced slew total", {32'd0, ts64}, 96'(61 * P + 41 * 10 + 20 * 3));
  endtask

  task automatic t_slew_zero();
    zero64_with_slew(4'd1, 16'd0, 16'd0);
    chk("R7 zero count not active", {95'd0, ofs_active}, '0);
    repeat (5) tick();
    chk("R7 zero count no effect", {32'd0, ts64}, 96'(5 * P));
  endtask

  task automatic t_drift();
    drf_ns = 0; drf_fns = 16'd20; drf_rate = 16'd5; drf_vld = 1'b1;
    ld64_val = '0; ld64_vld = 1'b1;
    tick();
    drf_vld = 1'b0; ld64_vld = 1'b0;
    repeat (10) tick();
    chk("R8 drift every 5th edge", {32'd0, ts64}, 96'(10 * P + 40));
    drf_ns = 0; drf_fns = 16'd3; drf_rate = 16'd1; drf_vld = 1'b1;
    ld64_val = '0; ld64_vld = 1'b1;
    tick();
    drf_vld = 1'b0; ld64_vld = 1'b0;
    repeat (4) tick();
    chk("R8 drift every edge", {32'd0, ts64}, 96'(4 * P + 12));
  endtask

  initial begin
    t_reset_defaults();
    t_loads();
    t_period();
    t_rollover();
    t_slew();
    t_slew_replace();
    t_slew_zero();
    t_drift();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule